// File: doc/BRIEF.md
# Key/Value Associative Store with Replacement

This block holds a small set of key/value pairs and looks them up by key, comparing the probe against every occupied entry at once. A lookup request carries a key. One cycle after it is accepted, a registered response reports whether the key is present and, when it is, the value stored with it. A store request carries a key and a value. If the key is already held, only its value changes. If the key is new, it takes a free entry. When no entry is free, it displaces an existing one, so a store is never refused.

The displaced entry depends on the `POLICY` parameter. `REPL_OLDEST_WRITE` discards the pair whose key was inserted longest ago. `REPL_LEAST_SEARCHED` discards the pair that has gone longest without a lookup hit, and a fresh insertion counts as a use. Each entry carries an age rank that encodes this ordering.

The lookup path uses valid/ready with back-pressure on the response. A new lookup is accepted while the response slot is empty or is being drained in the same cycle: `srch_ready = !rsp_valid || rsp_ready`. A pending response stays unchanged until `rsp_ready` takes it. The store path is always accepted: `wr_ready` is held high.

Top module: `kv_cam`

## Requirements
- R1: After reset, `rsp_valid` is 0 and no entry is occupied, so every lookup reports not found.
- R2: A lookup accepted in cycle t gives `rsp_valid`=1 in cycle t+1. When its key is stored, the response has `rsp_found`=1 and the value last written for that key.
- R3: A lookup whose key is absent responds with `rsp_found`=0 and `rsp_value`=0.
- R4: A store of a new key while any entry is free occupies that entry and removes no stored pair; occupancy never decreases.
- R5: A store whose key is already present replaces that entry's value in place, evicts nothing, and no key is ever held twice.
- R6: With `POLICY`=`REPL_OLDEST_WRITE`, a new-key store into a full store evicts the key inserted earliest. Lookups and value updates do not alter that order.
- R7: With `POLICY`=`REPL_LEAST_SEARCHED`, a new-key store into a full store evicts the key whose latest lookup hit or insertion is the oldest. Value updates do not count as a use.
- R8: When a lookup and a store are accepted in the same cycle, the lookup reports the contents from before the store. The store chooses its victim from the ranks as they stood before that lookup's hit.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `srch_ready` is 0 and `rsp_valid`, `rsp_found` and `rsp_value` hold. With no accepted lookup and `rsp_ready`=1, `rsp_valid` drops next cycle.
- R10: `wr_ready` is always 1, and a store takes effect in the cycle `wr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_valid | input | 1 | Lookup request valid |
| srch_ready | output | 1 | Lookup request accepted when high with srch_valid |
| srch_key | input | KEY_W | Key to look up |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_found | output | 1 | Key was present |
| rsp_value | output | VAL_W | Value paired with the key, zero on a miss |
| wr_valid | input | 1 | Store request valid |
| wr_ready | output | 1 | Store accepted (always high) |
| wr_key | input | KEY_W | Key to store |
| wr_value | input | VAL_W | Value to store |

## Verification
The bench builds two copies with `ENTRIES`=4, `KEY_W`=4 and `VAL_W`=8, one per `POLICY` value, and drives both with identical stimulus. Random keys come from only eight values, so the four entries fill within a few stores and evictions are frequent. Hits, misses, in-place updates and same-cycle lookup/store collisions all recur many times. Feeding both policies the same sequence exposes any case where they must pick different victims, such as a lookup hit on the oldest-inserted key just before a store.

// File: rtl/kv_cam_pkg.sv
package kv_cam_pkg;
  typedef enum logic {
    REPL_OLDEST_WRITE   = 1'b0,
    REPL_LEAST_SEARCHED = 1'b1
  } repl_policy_e;
endpackage

// File: rtl/kv_cam_match.sv
// Parallel key compare over all entries; returns the hit vector,
// the hit index and the paired value (zero when nothing matches).
module kv_cam_match #(
  parameter int N     = 8,
  parameter int KEY_W = 16,
  parameter int VAL_W = 32,
  parameter int IDX_W = 3
) (
  input  logic [KEY_W-1:0] keys [N],
  input  logic [VAL_W-1:0] vals [N],
  input  logic [N-1:0]     vld,
  input  logic [KEY_W-1:0] key,
  output logic [N-1:0]     hit_vec,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [VAL_W-1:0] hit_val
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (keys[i] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    hit_val = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        hit_idx = hit_idx | IDX_W'(i);
        hit_val = hit_val | vals[i];
      end
    end
  end
endmodule

// File: rtl/kv_cam_age.sv
// Per-entry age ranks (0 = youngest, N-1 = oldest) kept as a permutation.
// Two ordered touches per cycle; victim = lowest free entry, else oldest.
module kv_cam_age #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     vld,
  input  logic             touch_a,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             touch_b,
  input  logic [IDX_W-1:0] b_idx,
  output logic [IDX_W-1:0] victim
);
  typedef logic [IDX_W-1:0] rank_t;

  rank_t rank_q [N];
  rank_t step1  [N];
  rank_t step2  [N];
  rank_t a_rank, b_rank;
  logic  free_seen;

  always_comb begin
    a_rank = rank_q[a_idx];
    for (int j = 0; j < N; j++) begin
      step1[j] = rank_q[j];
      if (touch_a) begin
        if (IDX_W'(j) == a_idx)       step1[j] = '0;
        else if (rank_q[j] < a_rank)  step1[j] = rank_q[j] + 1'b1;
      end
    end
    b_rank = step1[b_idx];
    for (int j = 0; j < N; j++) begin
      step2[j] = step1[j];
      if (touch_b) begin
        if (IDX_W'(j) == b_idx)       step2[j] = '0;
        else if (step1[j] < b_rank)   step2[j] = step1[j] + 1'b1;
      end
    end
  end

  always_comb begin
    victim    = '0;
    free_seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!vld[i] && !free_seen) begin
        victim    = IDX_W'(i);
        free_seen = 1'b1;
      end
    end
    if (!free_seen) begin
      for (int i = 0; i < N; i++) begin
        if (rank_q[i] == IDX_W'(N - 1)) victim = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else begin
      for (int i = 0; i < N; i++) rank_q[i] <= step2[i];
    end
  end
endmodule

// File: rtl/kv_cam.sv
module kv_cam
  import kv_cam_pkg::*;
#(
  parameter int           ENTRIES = 8,
  parameter int           KEY_W   = 16,
  parameter int           VAL_W   = 32,
  parameter repl_policy_e POLICY  = REPL_LEAST_SEARCHED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srch_valid,
  output logic             srch_ready,
  input  logic [KEY_W-1:0] srch_key,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_found,
  output logic [VAL_W-1:0] rsp_value,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_value
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [VAL_W-1:0]   val_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [ENTRIES-1:0] s_hit_vec, w_hit_vec;
  logic               s_hit, w_hit;
  logic [IDX_W-1:0]   s_idx, w_idx, victim;
  logic [VAL_W-1:0]   s_val, w_val_unused;
  logic               srch_fire, wr_new, touch_search;

  kv_cam_match #(.N(ENTRIES), .KEY_W(KEY_W), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_srch_match (
    .keys(key_q), .vals(val_q), .vld(vld_q), .key(srch_key),
    .hit_vec(s_hit_vec), .hit(s_hit), .hit_idx(s_idx), .hit_val(s_val)
  );

  kv_cam_match #(.N(ENTRIES), .KEY_W(KEY_W), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_wr_match (
    .keys(key_q), .vals(val_q), .vld(vld_q), .key(wr_key),
    .hit_vec(w_hit_vec), .hit(w_hit), .hit_idx(w_idx), .hit_val(w_val_unused)
  );

  assign srch_ready = !rsp_valid || rsp_ready;
  assign wr_ready   = 1'b1;
  assign srch_fire  = srch_valid && srch_ready;
  assign wr_new     = wr_valid && !w_hit;

  // Only the search-recency variant lets a hit refresh an entry's rank.
  if (POLICY == REPL_LEAST_SEARCHED) begin : g_search_touch
    assign touch_search = srch_fire && s_hit;
  end else begin : g_insert_only
    assign touch_search = 1'b0;
  end

  kv_cam_age #(.N(ENTRIES), .IDX_W(IDX_W)) u_age (
    .clk(clk), .rst_n(rst_n), .vld(vld_q),
    .touch_a(touch_search), .a_idx(s_idx),
    .touch_b(wr_new), .b_idx(victim),
    .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_new) begin
      vld_q[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid) begin
      if (w_hit) begin
        val_q[w_idx] <= wr_value;
      end else begin
        key_q[victim] <= wr_key;
        val_q[victim] <= wr_value;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_value <= '0;
    end else if (srch_fire) begin
      rsp_valid <= 1'b1;
      rsp_found <= s_hit;
      rsp_value <= s_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/kv_cam_chk.sv
module kv_cam_chk #(
  parameter int ENTRIES = 8,
  parameter int VAL_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srch_valid,
  input logic               srch_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_found,
  input logic [VAL_W-1:0]   rsp_value,
  input logic [ENTRIES-1:0] s_hit_vec,
  input logic [ENTRIES-1:0] w_hit_vec,
  input logic [ENTRIES-1:0] vld
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && srch_ready) |=> rsp_valid); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_found) |-> (rsp_value == '0)); // R3
  AST_OCC_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(vld) >= $past($countones(vld)))); // R4
  AST_UNIQUE_SRCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_hit_vec)); // R5
  AST_UNIQUE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(w_hit_vec)); // R5
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_found) && $stable(rsp_value))); // R9
  AST_RSP_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!(srch_valid && srch_ready) && rsp_ready) |=> !rsp_valid); // R9
endmodule

bind kv_cam kv_cam_chk #(.ENTRIES(ENTRIES), .VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_ready(srch_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_found(rsp_found),
  .rsp_value(rsp_value), .s_hit_vec(s_hit_vec), .w_hit_vec(w_hit_vec), .vld(vld_q)
);

// File: tb/kv_cam_bench.sv
module kv_cam_bench;
  import kv_cam_pkg::*;
  localparam int N  = 4;
  localparam int KW = 4;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          srch_valid = 1'b0, rsp_ready = 1'b1, wr_valid = 1'b0;
  logic [KW-1:0] srch_key = '0, wr_key = '0;
  logic [VW-1:0] wr_value = '0;

  // index 0: oldest-write policy, index 1: least-searched policy
  logic          srdy [2];
  logic          wrdy [2];
  logic          rv   [2];
  logic          rf   [2];
  logic [VW-1:0] rval [2];

  kv_cam #(.ENTRIES(N), .KEY_W(KW), .VAL_W(VW), .POLICY(REPL_LEAST_SEARCHED)) u_kv_cam (
    .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_ready(srdy[1]),
    .srch_key(srch_key), .rsp_valid(rv[1]), .rsp_ready(rsp_ready), .rsp_found(rf[1]),
    .rsp_value(rval[1]), .wr_valid(wr_valid), .wr_ready(wrdy[1]), .wr_key(wr_key),
    .wr_value(wr_value));

  kv_cam #(.ENTRIES(N), .KEY_W(KW), .VAL_W(VW), .POLICY(REPL_OLDEST_WRITE)) u_kv_cam_ins (
    .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_ready(srdy[0]),
    .srch_key(srch_key), .rsp_valid(rv[0]), .rsp_ready(rsp_ready), .rsp_found(rf[0]),
    .rsp_value(rval[0]), .wr_valid(wr_valid), .wr_ready(wrdy[0]), .wr_key(wr_key),
    .wr_value(wr_value));

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference model: key-based slots with use stamps.
  logic [KW-1:0] m_key [2][N];
  logic [VW-1:0] m_val [2][N];
  bit            m_vld [2][N];
  int            m_stamp [2][N];
  int            tick = 0;
  bit            e_v [2];
  bit            e_f [2];
  logic [VW-1:0] e_val [2];

  function automatic int m_find(int p, logic [KW-1:0] k);
    for (int i = 0; i < N; i++) if (m_vld[p][i] && m_key[p][i] == k) return i;
    return -1;
  endfunction

  function automatic int m_victim(int p);
    int best = 0;
    for (int i = 0; i < N; i++) if (!m_vld[p][i]) return i;
    for (int i = 1; i < N; i++) if (m_stamp[p][i] < m_stamp[p][best]) best = i;
    return best;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(bit sv, logic [KW-1:0] sk, bit wv, logic [KW-1:0] wk,
                       logic [VW-1:0] wd, bit rr, string tag);
    bit fire;
    @(negedge clk);
    srch_valid = sv; srch_key = sk; wr_valid = wv; wr_key = wk; wr_value = wd;
    rsp_ready = rr;
    #1;
    fire = sv && srdy[1];
    check("R9", {31'b0, srdy[0]}, {31'b0, srdy[1]}, "srch_ready agreement");
    check("R10", {30'b0, wrdy[1], wrdy[0]}, 32'd3, "wr_ready");
    for (int p = 0; p < 2; p++) begin
      int si, wi, vic;
      si = -1; wi = -1; vic = -1;
      if (fire) begin
        si = m_find(p, sk);
        e_v[p] = 1'b1;
        e_f[p] = (si >= 0);
        e_val[p] = (si >= 0) ? m_val[p][si] : '0;
      end else if (rr) begin
        e_v[p] = 1'b0;
      end
      if (wv) begin
        wi = m_find(p, wk);
        if (wi < 0) vic = m_victim(p);
      end
      if (fire && p == 1 && si >= 0) begin
        tick++;
        m_stamp[p][si] = tick;
      end
      if (wv) begin
        if (wi >= 0) m_val[p][wi] = wd;
        else begin
          tick++;
          m_key[p][vic] = wk; m_val[p][vic] = wd; m_vld[p][vic] = 1'b1;
          m_stamp[p][vic] = tick;
        end
      end
    end
    @(posedge clk);
    #1;
    for (int p = 0; p < 2; p++) begin
      check(tag, {31'b0, rv[p]}, {31'b0, e_v[p]}, p ? "valid/search" : "valid/insert");
      if (e_v[p]) begin
        check(tag, {31'b0, rf[p]}, {31'b0, e_f[p]}, p ? "found/search" : "found/insert");
        check(tag, {24'b0, rval[p]}, {24'b0, e_val[p]}, p ? "value/search" : "value/insert");
      end
    end
  endtask

  task automatic idle();
    cycle(1'b0, '0, 1'b0, '0, '0, 1'b1, "R9");
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int p = 0; p < 2; p++) begin
      e_v[p] = 1'b0; e_f[p] = 1'b0; e_val[p] = '0;
      for (int i = 0; i < N; i++) begin
        m_vld[p][i] = 1'b0; m_key[p][i] = '0; m_val[p][i] = '0; m_stamp[p][i] = 0;
      end
    end
    repeat (4) @(posedge clk);
    #1;
    check("R1", {31'b0, rv[0] | rv[1]}, 32'd0, "rsp_valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    for (int k = 0; k < 4; k++) cycle(1'b1, KW'(k), 1'b0, '0, '0, 1'b1, "R1");
    // R4: fill free entries
    for (int k = 1; k <= 4; k++) cycle(1'b0, '0, 1'b1, KW'(k), VW'(8'h10 + k), 1'b1, "R4");
    for (int k = 1; k <= 4; k++) cycle(1'b1, KW'(k), 1'b0, '0, '0, 1'b1, "R2");
    cycle(1'b1, 4'd9, 1'b0, '0, '0, 1'b1, "R3");
    // R5: in-place update
    cycle(1'b0, '0, 1'b1, 4'd3, 8'hA3, 1'b1, "R5");
    cycle(1'b1, 4'd3, 1'b0, '0, '0, 1'b1, "R5");
    // R6/R7: refresh key 1 by search, then insert 5 into full store
    cycle(1'b1, 4'd1, 1'b0, '0, '0, 1'b1, "R7");
    cycle(1'b0, '0, 1'b1, 4'd5, 8'h55, 1'b1, "R6");
    cycle(1'b1, 4'd1, 1'b0, '0, '0, 1'b1, "R6");
    cycle(1'b1, 4'd2, 1'b0, '0, '0, 1'b1, "R7");
    cycle(1'b1, 4'd5, 1'b0, '0, '0, 1'b1, "R7");
    // R8: same-cycle search and write
    cycle(1'b1, 4'd6, 1'b1, 4'd6, 8'h66, 1'b1, "R8");
    cycle(1'b1, 4'd6, 1'b1, 4'd6, 8'h67, 1'b1, "R8");
    cycle(1'b1, 4'd6, 1'b0, '0, '0, 1'b1, "R8");
    // R9: back-pressure holds the response and refuses new searches
    cycle(1'b1, 4'd6, 1'b0, '0, '0, 1'b0, "R9");
    cycle(1'b1, 4'd9, 1'b0, '0, '0, 1'b0, "R9");
    cycle(1'b1, 4'd9, 1'b0, '0, '0, 1'b0, "R9");
    cycle(1'b0, '0, 1'b0, '0, '0, 1'b1, "R9");
    idle();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit sv, wv, rr;
      logic [KW-1:0] sk, wk;
      sv = ($urandom_range(0, 3) != 0);
      wv = ($urandom_range(0, 2) == 0);
      rr = ($urandom_range(0, 4) != 0);
      sk = KW'($urandom_range(0, 7));
      wk = KW'($urandom_range(0, 7));
      cycle(sv, sk, wv, wk, VW'($urandom), rr, "R2");
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule